// File: doc/BRIEF.md
# Segment Register Load Checker

This block decides the outcome when a 16-bit selector is written into one of the five data or stack segment registers of a segmented processor. It receives the destination register code, the selector, the current privilege level, three mode flags and the 64-bit descriptor that a separate fetch unit has already read from the descriptor table. From these it either updates that register's selector and its hidden descriptor cache, or reports a fault with a class and an error code. The descriptor fetch and the write that sets the accessed bit are done elsewhere. This block only raises a one-cycle request for the accessed-bit write.

One load is taken per `start` pulse. The result is registered and shows on the cycle after `start`. The stored cache of any register can be read at any time through a combinational read port. The rest of the pipeline uses that port for address generation and limit checks. Real-mode and virtual-8086 loads skip every descriptor check and take their own cache update paths.

Top module: `seg_load_check`

## Requirements
- R1: After reset, `done`, `fault`, `acc_req` and `bad_id` are 0, `fault_cls` is 0, and every register cache reads back with `rd_valid` = 0 and all fields 0.
- R2: `done` is 1 exactly in the cycle after a cycle with `start` = 1, and 0 otherwise. A fault is reported only together with `done`.
- R3: Register codes are `seg_id` 0 = DS, 1 = ES, 2 = FS, 3 = GS, 4 = SS. A selector is null when bits 15:2 are all zero. A null load into codes 0 to 3 succeeds without checks and sets the cache to selector 0, valid 0, access byte 8'h10, base 0, limit 0, flags 0.
- R4: A null load into SS gives a general-protection fault with error code 0. The exception is when `long64` = 1 (with parameter LONG_MODE_EN = 1), `cpl` is not 3 and the selector's RPL (bits 1:0) equals `cpl`. In that case it loads the null cache of R3.
- R5: For an SS load, each of these gives a general-protection fault: RPL not equal to `cpl`, a system descriptor, a code segment, a read-only data segment, or DPL not equal to `cpl`. Only when none of these applies does a clear present bit give a stack fault. `fault_cls` encodes 1 = general protection, 2 = stack, 3 = not present, 0 = no fault.
- R6: For a DS, ES, FS or GS load, a general-protection fault results from any of these: a system descriptor, execute-only code, or (for data or non-conforming code) RPL or `cpl` greater than DPL. Conforming readable code skips the privilege test. After these checks, a clear present bit gives a not-present fault.
- R7: On a fault, `err_code` is the selector with bits 1:0 cleared, and the target register's cache is left unchanged.
- R8: The descriptor's high dword is bits 63:32. Its access byte is bits 47:40, laid out as present (bit 7), DPL (bits 6:5), code/data flag (bit 4) and type (bits 3:0). Type bit 3 means code, bit 2 means conforming, bit 1 means readable code or writable data, and bit 0 is the accessed flag. A successful protected load stores the selector, valid = 1, `rd_ar` = the access byte, base = {desc[63:56], desc[39:16]} and `rd_flags` = {G, D/B, L, AVL} = desc[55:52].
- R9: The raw limit is {desc[51:48], desc[15:0]}. The stored limit is {raw, 12'hFFF} when G (bit 55) is set, and the raw limit otherwise.
- R10: With `real_mode` = 1 (which takes priority over `v86_mode`), a load into any valid code sets selector, valid = 1, base = selector × 16, present = 1, code/data flag = 1 and type = 4'h3. The DPL, limit and flags stay as they were.
- R11: With `v86_mode` = 1 and `real_mode` = 0, a load sets the same fields as R10 and also sets DPL = 3 (so `rd_ar` = 8'hF3), limit = 32'h0000FFFF and flags = 0.
- R12: `acc_req` pulses with `done` only for a successful protected-mode non-null load whose descriptor bit 40 is 0.
- R13: A `seg_id` of 5 to 7 gives `done` with `bad_id` = 1, no fault and no accessed request, and changes no cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Process one load this cycle |
| seg_id | input | 3 | Destination register code |
| selector | input | 16 | Selector being loaded |
| cpl | input | 2 | Current privilege level |
| real_mode | input | 1 | Real-address mode |
| v86_mode | input | 1 | Virtual-8086 mode |
| long64 | input | 1 | 64-bit sub-mode |
| desc | input | 64 | Fetched descriptor |
| rd_id | input | 3 | Register code for cache readout |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Load faulted |
| fault_cls | output | 2 | Fault class |
| err_code | output | 16 | Fault error code |
| acc_req | output | 1 | Accessed-bit writeback request |
| bad_id | output | 1 | Unsupported register code |
| rd_sel | output | 16 | Stored selector |
| rd_valid | output | 1 | Cache valid |
| rd_ar | output | 8 | Stored access byte |
| rd_base | output | 32 | Stored base |
| rd_limit | output | 32 | Stored scaled limit |
| rd_flags | output | 4 | Stored G, D/B, L, AVL |

## Verification
The bench builds the block with its default LONG_MODE_EN = 1. This brings the 64-bit null-stack exception of R4 within reach, alongside the ordinary null-stack fault. That lets one run compare the accepted and rejected null SS loads that differ only in `long64` and the privilege level. The descriptor cases are chosen so that a low-priority condition (not present) is combined with a higher-priority one (RPL mismatch). This shows that the fault class follows the check order, not just the presence of a failure.

// File: rtl/seg_load_check.sv
module seg_load_check #(
  parameter bit LONG_MODE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  seg_id,
  input  logic [15:0] selector,
  input  logic [1:0]  cpl,
  input  logic        real_mode,
  input  logic        v86_mode,
  input  logic        long64,
  input  logic [63:0] desc,
  input  logic [2:0]  rd_id,
  output logic        done,
  output logic        fault,
  output logic [1:0]  fault_cls,
  output logic [15:0] err_code,
  output logic        acc_req,
  output logic        bad_id,
  output logic [15:0] rd_sel,
  output logic        rd_valid,
  output logic [7:0]  rd_ar,
  output logic [31:0] rd_base,
  output logic [31:0] rd_limit,
  output logic [3:0]  rd_flags
);

  localparam int       NSEG    = 5;
  localparam logic [2:0] ID_SS = 3'd4;
  localparam logic [1:0] CLS_NONE = 2'd0;
  localparam logic [1:0] CLS_GP   = 2'd1;
  localparam logic [1:0] CLS_STK  = 2'd2;
  localparam logic [1:0] CLS_NP   = 2'd3;

  typedef enum logic [2:0] {ACT_NONE, ACT_NULL, ACT_LOAD, ACT_REAL, ACT_V86} act_t;

  logic [15:0] c_sel   [NSEG];
  logic        c_valid [NSEG];
  logic [7:0]  c_ar    [NSEG];
  logic [31:0] c_base  [NSEG];
  logic [31:0] c_limit [NSEG];
  logic [3:0]  c_flags [NSEG];

  wire       id_ok   = seg_id < 3'(NSEG);
  wire       is_ss   = seg_id == ID_SS;
  wire [1:0] rpl     = selector[1:0];
  wire       is_null = selector[15:2] == 14'd0;

  wire [7:0]  d_ar    = desc[47:40];
  wire        d_p     = d_ar[7];
  wire [1:0]  d_dpl   = d_ar[6:5];
  wire        d_s     = d_ar[4];
  wire        d_code  = d_ar[3];
  wire        d_conf  = d_ar[2];
  wire        d_rw    = d_ar[1];
  wire [31:0] d_base  = {desc[63:56], desc[39:16]};
  wire [19:0] d_lim   = {desc[51:48], desc[15:0]};
  wire [3:0]  d_flags = desc[55:52];
  wire [31:0] d_scaled = desc[55] ? {d_lim, 12'hFFF} : {12'h000, d_lim};

  act_t       act;
  logic [1:0] cls;

  always_comb begin
    act = ACT_NONE;
    cls = CLS_NONE;
    if (!id_ok) begin
      act = ACT_NONE;
    end else if (real_mode) begin
      act = ACT_REAL;
    end else if (v86_mode) begin
      act = ACT_V86;
    end else if (is_ss) begin
      if (is_null) begin
        if (LONG_MODE_EN && long64 && cpl != 2'd3 && rpl == cpl) act = ACT_NULL;
        else cls = CLS_GP;
      end else if (rpl != cpl) cls = CLS_GP;
      else if (!d_s || d_code || !d_rw) cls = CLS_GP;
      else if (d_dpl != cpl) cls = CLS_GP;
      else if (!d_p) cls = CLS_STK;
      else act = ACT_LOAD;
    end else begin
      if (is_null) act = ACT_NULL;
      else if (!d_s || (d_code && !d_rw)) cls = CLS_GP;
      else if ((!d_code || !d_conf) && (rpl > d_dpl || cpl > d_dpl)) cls = CLS_GP;
      else if (!d_p) cls = CLS_NP;
      else act = ACT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        c_sel[i]   <= '0;
        c_valid[i] <= 1'b0;
        c_ar[i]    <= '0;
        c_base[i]  <= '0;
        c_limit[i] <= '0;
        c_flags[i] <= '0;
      end
    end else if (start) begin
      for (int i = 0; i < NSEG; i++) begin
        if (3'(i) == seg_id) begin
          case (act)
            ACT_NULL: begin
              c_sel[i]   <= '0;
              c_valid[i] <= 1'b0;
              c_ar[i]    <= 8'h10;
              c_base[i]  <= '0;
              c_limit[i] <= '0;
              c_flags[i] <= '0;
            end
            ACT_LOAD: begin
              c_sel[i]   <= selector;
              c_valid[i] <= 1'b1;
              c_ar[i]    <= d_ar;
              c_base[i]  <= d_base;
              c_limit[i] <= d_scaled;
              c_flags[i] <= d_flags;
            end
            ACT_REAL: begin
              c_sel[i]   <= selector;
              c_valid[i] <= 1'b1;
              c_ar[i]    <= {1'b1, c_ar[i][6:5], 1'b1, 4'h3};
              c_base[i]  <= {12'h000, selector, 4'h0};
            end
            ACT_V86: begin
              c_sel[i]   <= selector;
              c_valid[i] <= 1'b1;
              c_ar[i]    <= 8'hF3;
              c_base[i]  <= {12'h000, selector, 4'h0};
              c_limit[i] <= 32'h0000_FFFF;
              c_flags[i] <= 4'h0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      fault     <= 1'b0;
      fault_cls <= CLS_NONE;
      err_code  <= '0;
      acc_req   <= 1'b0;
      bad_id    <= 1'b0;
    end else begin
      done      <= start;
      fault     <= start && cls != CLS_NONE;
      fault_cls <= start ? cls : CLS_NONE;
      err_code  <= (start && cls != CLS_NONE) ? {selector[15:2], 2'b00} : 16'h0000;
      acc_req   <= start && act == ACT_LOAD && !desc[40];
      bad_id    <= start && !id_ok;
    end
  end

  always_comb begin
    rd_sel   = '0;
    rd_valid = 1'b0;
    rd_ar    = '0;
    rd_base  = '0;
    rd_limit = '0;
    rd_flags = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (3'(i) == rd_id) begin
        rd_sel   = c_sel[i];
        rd_valid = c_valid[i];
        rd_ar    = c_ar[i];
        rd_base  = c_base[i];
        rd_limit = c_limit[i];
        rd_flags = c_flags[i];
      end
    end
  end

endmodule

module seg_load_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_cls,
  input logic [15:0] err_code,
  input logic        acc_req,
  input logic        bad_id
);

  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R2
  fault_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  // R5
  fault_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (fault_cls != 2'd0));

  // R7
  err_code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> err_code[1:0] == 2'b00);

  // R12
  acc_req_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> (done && !fault && !bad_id));

  // R13
  bad_id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_id |-> (done && !fault));

endmodule

bind seg_load_check seg_load_check_sva u_sva (.*);

// File: tb/test_seg_load_check.sv
`timescale 1ns/1ps
module test_seg_load_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  seg_id = '0;
  logic [15:0] selector = '0;
  logic [1:0]  cpl = '0;
  logic        real_mode = 1'b0, v86_mode = 1'b0, long64 = 1'b0;
  logic [63:0] desc = '0;
  logic [2:0]  rd_id = '0;
  logic        done, fault, acc_req, bad_id, rd_valid;
  logic [1:0]  fault_cls;
  logic [15:0] err_code, rd_sel;
  logic [7:0]  rd_ar;
  logic [31:0] rd_base, rd_limit;
  logic [3:0]  rd_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit        f;
    bit [1:0]  c;
    bit [15:0] e;
    bit        a;
    bit        b;
    string     req;
  } exp_t;
  exp_t q[$];

  seg_load_check i_seg_load_check (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [31:0] base, logic [19:0] lim, logic p, logic [1:0] dpl,
                                     logic s, logic [3:0] typ, logic [3:0] flg);
    return {base[31:24], flg, lim[19:16], p, dpl, s, typ, base[23:16], base[15:0], lim[15:0]};
  endfunction

  task automatic issue(input [2:0] id, input [15:0] sel, input [1:0] c, input bit rm, input bit vm,
                       input bit lm, input [63:0] d, input bit ef, input [1:0] ec, input bit ea,
                       input bit eb, input string req);
    exp_t e;
    @(negedge clk);
    seg_id = id; selector = sel; cpl = c; real_mode = rm; v86_mode = vm; long64 = lm; desc = d;
    start = 1'b1;
    e.f = ef; e.c = ec; e.e = ef ? {sel[15:2], 2'b00} : 16'h0; e.a = ea; e.b = eb; e.req = req;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0; real_mode = 1'b0; v86_mode = 1'b0; long64 = 1'b0;
  endtask

  task automatic cache(input string req, input [2:0] id, input [15:0] sel, input bit v, input [7:0] ar,
                       input [31:0] base, input [31:0] lim, input [3:0] flg);
    rd_id = id;
    #1;
    chk(req, "rd_sel", 32'(rd_sel), 32'(sel));
    chk(req, "rd_valid", 32'(rd_valid), 32'(v));
    chk(req, "rd_ar", 32'(rd_ar), 32'(ar));
    chk(req, "rd_base", rd_base, base);
    chk(req, "rd_limit", rd_limit, lim);
    chk(req, "rd_flags", 32'(rd_flags), 32'(flg));
  endtask

  // monitor: R2 R5 R6 R7 R12 R13
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk("R2", "unexpected done", 32'(done), 32'd0);
      end else begin
        automatic exp_t e = q.pop_front();
        chk(e.req, "fault", 32'(fault), 32'(e.f));
        chk(e.req, "fault_cls", 32'(fault_cls), 32'(e.c));
        chk(e.req, "err_code", 32'(err_code), 32'(e.e));
        chk(e.req, "acc_req", 32'(acc_req), 32'(e.a));
        chk(e.req, "bad_id", 32'(bad_id), 32'(e.b));
      end
    end else if (rst_n && q.size() != 0 && !start) begin
      chk("R2", "missing done", 32'(done), 32'd1);
      void'(q.pop_front());
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", 32'(done), 0);
    chk("R1", "fault", 32'(fault), 0);
    chk("R1", "acc_req", 32'(acc_req), 0);
    for (int i = 0; i < 5; i++) cache("R1", 3'(i), 16'h0, 0, 8'h00, 0, 0, 4'h0);

    // R8 R9 R12 DS good, byte granular, accessed clear
    issue(3'd0, 16'h0013, 2'd3, 0, 0, 0, mk(32'h12345678, 20'hABCDE, 1, 2'd3, 1, 4'h2, 4'h4),
          0, 2'd0, 1, 0, "R8");
    cache("R8", 3'd0, 16'h0013, 1, 8'hF2, 32'h12345678, 32'h000ABCDE, 4'h4);
    // R9 R12 ES page granular, already accessed
    issue(3'd1, 16'h002B, 2'd3, 0, 0, 0, mk(32'h00100000, 20'h00012, 1, 2'd3, 1, 4'h3, 4'hB),
          0, 2'd0, 0, 0, "R9");
    cache("R9", 3'd1, 16'h002B, 1, 8'hF3, 32'h00100000, 32'h00012FFF, 4'hB);
    // R6 FS readable non-conforming code, privileges equal
    issue(3'd2, 16'h0008, 2'd0, 0, 0, 0, mk(32'hFFFF0000, 20'h34567, 1, 2'd0, 1, 4'hA, 4'h5),
          0, 2'd0, 1, 0, "R6");
    cache("R6", 3'd2, 16'h0008, 1, 8'h9A, 32'hFFFF0000, 32'h00034567, 4'h5);
    // R6 R7 GS execute-only code
    issue(3'd3, 16'h0107, 2'd3, 0, 0, 0, mk(0, 20'hFFFF, 1, 2'd3, 1, 4'h8, 0), 1, 2'd1, 0, 0, "R6");
    cache("R7", 3'd3, 16'h0, 0, 8'h00, 0, 0, 4'h0);
    // R6 data privilege violations
    issue(3'd0, 16'h0022, 2'd3, 0, 0, 0, mk(0, 20'hFFF, 1, 2'd2, 1, 4'h2, 0), 1, 2'd1, 0, 0, "R6");
    issue(3'd0, 16'h0023, 2'd0, 0, 0, 0, mk(0, 20'hFFF, 1, 2'd2, 1, 4'h2, 0), 1, 2'd1, 0, 0, "R6");
    // R6 conforming readable code skips privilege
    issue(3'd0, 16'h0033, 2'd3, 0, 0, 0, mk(0, 20'h00FFF, 1, 2'd0, 1, 4'hE, 0), 0, 2'd0, 1, 0, "R6");
    cache("R6", 3'd0, 16'h0033, 1, 8'h9E, 0, 32'h00000FFF, 4'h0);
    // R6 R7 not present
    issue(3'd0, 16'h0043, 2'd3, 0, 0, 0, mk(0, 20'hFFF, 0, 2'd3, 1, 4'h2, 0), 1, 2'd3, 0, 0, "R6");
    cache("R7", 3'd0, 16'h0033, 1, 8'h9E, 0, 32'h00000FFF, 4'h0);
    // R6 system descriptor
    issue(3'd0, 16'h0053, 2'd3, 0, 0, 0, mk(0, 20'hFFF, 1, 2'd3, 0, 4'h2, 0), 1, 2'd1, 0, 0, "R6");
    // R3 null into DS
    issue(3'd0, 16'h0003, 2'd3, 0, 0, 0, 64'h0, 0, 2'd0, 0, 0, "R3");
    cache("R3", 3'd0, 16'h0, 0, 8'h10, 0, 0, 4'h0);
    // R4 null SS variants
    issue(3'd4, 16'h0000, 2'd0, 0, 0, 0, 64'h0, 1, 2'd1, 0, 0, "R4");
    issue(3'd4, 16'h0000, 2'd0, 0, 0, 1, 64'h0, 0, 2'd0, 0, 0, "R4");
    cache("R4", 3'd4, 16'h0, 0, 8'h10, 0, 0, 4'h0);
    issue(3'd4, 16'h0003, 2'd3, 0, 0, 1, 64'h0, 1, 2'd1, 0, 0, "R4");
    // R5 SS ordering
    issue(3'd4, 16'h0011, 2'd0, 0, 0, 0, mk(0, 20'hFFF, 0, 2'd0, 1, 4'h2, 0), 1, 2'd1, 0, 0, "R5");
    issue(3'd4, 16'h0010, 2'd0, 0, 0, 0, mk(0, 20'hFFF, 1, 2'd0, 1, 4'h0, 0), 1, 2'd1, 0, 0, "R5");
    issue(3'd4, 16'h0010, 2'd0, 0, 0, 0, mk(0, 20'hFFF, 1, 2'd0, 1, 4'hA, 0), 1, 2'd1, 0, 0, "R5");
    issue(3'd4, 16'h0010, 2'd0, 0, 0, 0, mk(0, 20'hFFF, 1, 2'd1, 1, 4'h2, 0), 1, 2'd1, 0, 0, "R5");
    issue(3'd4, 16'h0010, 2'd0, 0, 0, 0, mk(0, 20'hFFF, 0, 2'd0, 1, 4'h2, 0), 1, 2'd2, 0, 0, "R5");
    issue(3'd4, 16'h0010, 2'd0, 0, 0, 0, mk(32'h2000, 20'hFFFFF, 1, 2'd0, 1, 4'h3, 4'h8),
          0, 2'd0, 0, 0, "R5");
    cache("R9", 3'd4, 16'h0010, 1, 8'h93, 32'h2000, 32'hFFFFFFFF, 4'h8);
    // R10 real mode keeps limit, flags, DPL
    issue(3'd2, 16'h1234, 2'd0, 1, 1, 0, 64'h0, 0, 2'd0, 0, 0, "R10");
    cache("R10", 3'd2, 16'h1234, 1, 8'h93, 32'h00012340, 32'h00034567, 4'h5);
    // R11 virtual-8086
    issue(3'd3, 16'hF000, 2'd3, 0, 1, 0, 64'h0, 0, 2'd0, 0, 0, "R11");
    cache("R11", 3'd3, 16'hF000, 1, 8'hF3, 32'h000F0000, 32'h0000FFFF, 4'h0);
    // R13 unsupported code
    issue(3'd7, 16'h0010, 2'd0, 0, 0, 0, mk(0, 20'h1, 1, 2'd0, 1, 4'h2, 0), 0, 2'd0, 0, 1, "R13");
    cache("R13", 3'd4, 16'h0010, 1, 8'h93, 32'h2000, 32'hFFFFFFFF, 4'h8);
    // R2 idle: no done
    @(negedge clk);
    chk("R2", "idle done", 32'(done), 0);
    chk("R2", "queue empty", 32'(q.size()), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule